// File: doc/BRIEF.md
# Deep-Sleep Watchdog with Selectable Slow Clock

This block is a watchdog timer that runs only while the device is in its deepest sleep state. It wakes the device after a programmable delay. It counts ticks from one of two slow oscillators: an internal RC oscillator or a crystal oscillator. A static configuration bit picks the oscillator, and a 4-bit code sets the time-out length. Across the sixteen codes the delay ranges from a few milliseconds to several weeks. In this design each oscillator is represented by a tick enable in the system clock domain, together with a ready flag.

Each sleep-entry strobe restarts the count from zero. While the device sleeps, the block asks for its selected oscillator to be switched on. It counts only while that oscillator reports ready, so a slow oscillator start-up lengthens the time-out. When the count reaches the terminal value, the block emits a one-cycle wake pulse and sets a sticky flag. It then stays idle until the next sleep entry. A sleep-exit strobe from any other wake source stops the count. An asynchronous power-on reset clears all state; the reset is released synchronously.

Top module: `dslp_wdt`

## Requirements
- R1: While the power-on reset is held and after it is released, wake_pulse, wake_flag, rc_req and xtal_req are all 0.
- R2: With cfg_en = 0, a sleep entry does not arm the block: no oscillator request is raised and no wake pulse or wake flag follows.
- R3: Every sleep entry clears the count, so a second entry during counting restarts a complete period from that entry.
- R4: cfg_clk_sel = 0 counts only rc_tick and cfg_clk_sel = 1 counts only xtal_tick; ticks from the other source have no effect.
- R5: The terminal count is 2^(6 + 2*cfg_ps), so code 0 gives 64 ticks, code 1 gives 256, code 2 gives 1024 and code 4 gives 16384. wake_pulse is high in the cycle after the clock edge that takes the last of these ticks. The tick taken at the entry edge is not counted.
- R6: From the entry edge until time-out or exit, the request output of the selected source is 1 and the other request is 0.
- R7: A tick of the selected source is not counted while that source's ready input is 0.
- R8: wake_pulse lasts one cycle and sets wake_flag, which stays set. No further pulse follows until the next entry, however many ticks arrive.
- R9: A sleep entry clears wake_flag at its edge.
- R10: Counting happens only while the block is armed. A sleep_exit strobe disarms it, drops the request and prevents the wake pulse.
- R11: A sleep entry that falls on the same edge as the terminal tick takes precedence: no wake pulse comes from the old period and a full new period starts.
- R12: Asserting rst_n during counting clears the count, the request and the flag, and no wake pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| cfg_en | input | 1 | Watchdog enable configuration |
| cfg_clk_sel | input | 1 | Source select: 0 RC oscillator, 1 crystal oscillator |
| cfg_ps | input | 4 | Postscaler code |
| sleep_entry | input | 1 | One-cycle strobe on deep-sleep entry |
| sleep_exit | input | 1 | One-cycle strobe when another source ends the sleep |
| rc_tick | input | 1 | Tick enable standing in for the RC oscillator |
| rc_ready | input | 1 | RC oscillator running and stable |
| xtal_tick | input | 1 | Tick enable standing in for the crystal oscillator |
| xtal_ready | input | 1 | Crystal oscillator running and stable |
| wake_pulse | output | 1 | One-cycle time-out wake event |
| wake_flag | output | 1 | Sticky watchdog wake status |
| rc_req | output | 1 | Request to power the RC oscillator |
| xtal_req | output | 1 | Request to power the crystal oscillator |

## Verification
The race of interest is between a sleep entry and the terminal tick of a running period on the same edge. The bench starts a period with code 0 and then places a second entry strobe exactly on the edge where the 64th tick lands. The scoreboard expects no pulse from the first period and exactly one pulse a full 64 ticks after the second entry. A stray or misplaced pulse is reported as a mismatch.

// File: rtl/dslp_wdt_pkg.sv
package dslp_wdt_pkg;
  typedef enum logic {
    SRC_RC   = 1'b0,
    SRC_XTAL = 1'b1
  } src_e;
endpackage

// File: rtl/dslp_wdt_src.sv
module dslp_wdt_src
  import dslp_wdt_pkg::*;
(
  input  logic armed,
  input  logic en,
  input  logic sel,
  input  logic rc_tick,
  input  logic rc_ready,
  input  logic xtal_tick,
  input  logic xtal_ready,
  output logic tick_ok,
  output logic rc_req,
  output logic xtal_req
);
  src_e src;
  logic live;

  always_comb begin
    src      = src_e'(sel);
    live     = armed & en;
    rc_req   = live & (src == SRC_RC);
    xtal_req = live & (src == SRC_XTAL);
    if (src == SRC_XTAL) tick_ok = xtal_tick & xtal_ready;
    else                 tick_ok = rc_tick & rc_ready;
  end
endmodule

// File: rtl/dslp_wdt_count.sv
module dslp_wdt_count #(
  parameter int unsigned PS_W     = 4,
  parameter int unsigned EXP_BASE = 6,
  parameter int unsigned EXP_STEP = 2,
  parameter int unsigned CNT_W    = EXP_BASE + EXP_STEP * ((1 << PS_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [PS_W-1:0]  ps_code,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, mask;
  int unsigned      shamt;

  always_comb begin
    shamt = CNT_W - (EXP_BASE + EXP_STEP * int'(ps_code));
    mask  = ALL1 >> shamt;
    hit_o = inc && (cnt_q == mask);
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dslp_wdt_seq.sv
module dslp_wdt_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic entry,
  input  logic leave,
  input  logic hit,
  output logic armed_o,
  output logic pulse_o,
  output logic flag_o
);
  logic armed_q, armed_d, pulse_q, pulse_d, flag_q, flag_d;

  always_comb begin
    armed_d = armed_q;
    flag_d  = flag_q;
    pulse_d = 1'b0;
    if (entry) begin
      armed_d = en;
      flag_d  = 1'b0;
    end else if (leave) begin
      armed_d = 1'b0;
    end else if (hit) begin
      armed_d = 1'b0;
      flag_d  = 1'b1;
      pulse_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign armed_o = armed_q;
  assign pulse_o = pulse_q;
  assign flag_o  = flag_q;

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  p_flag_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> flag_q);
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> !flag_q);
endmodule

// File: rtl/dslp_wdt.sv
module dslp_wdt #(
  parameter int unsigned PS_W     = 4,
  parameter int unsigned EXP_BASE = 6,
  parameter int unsigned EXP_STEP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_clk_sel,
  input  logic [PS_W-1:0] cfg_ps,
  input  logic            sleep_entry,
  input  logic            sleep_exit,
  input  logic            rc_tick,
  input  logic            rc_ready,
  input  logic            xtal_tick,
  input  logic            xtal_ready,
  output logic            wake_pulse,
  output logic            wake_flag,
  output logic            rc_req,
  output logic            xtal_req
);
  localparam int unsigned CNT_W = EXP_BASE + EXP_STEP * ((1 << PS_W) - 1);

  logic [1:0]       rst_sync_q;
  logic             rst_s;
  logic             armed, tick_ok, inc, hit;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  dslp_wdt_src u_src (
    .armed(armed), .en(cfg_en), .sel(cfg_clk_sel),
    .rc_tick(rc_tick), .rc_ready(rc_ready),
    .xtal_tick(xtal_tick), .xtal_ready(xtal_ready),
    .tick_ok(tick_ok), .rc_req(rc_req), .xtal_req(xtal_req)
  );

  assign inc = armed & tick_ok & ~sleep_entry & ~sleep_exit;

  dslp_wdt_count #(
    .PS_W(PS_W), .EXP_BASE(EXP_BASE), .EXP_STEP(EXP_STEP), .CNT_W(CNT_W)
  ) u_count (
    .clk(clk), .rst_n(rst_s), .clr(sleep_entry), .inc(inc),
    .ps_code(cfg_ps), .cnt_o(cnt), .hit_o(hit)
  );

  dslp_wdt_seq u_seq (
    .clk(clk), .rst_n(rst_s), .en(cfg_en), .entry(sleep_entry),
    .leave(sleep_exit), .hit(hit),
    .armed_o(armed), .pulse_o(wake_pulse), .flag_o(wake_flag)
  );

  p_entry_clears_r3: assert property (@(posedge clk) disable iff (!rst_s)
    sleep_entry |=> (cnt == '0));
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (!tick_ok && !sleep_entry) |=> $stable(cnt));
  p_no_wake_idle_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !armed |=> !wake_pulse);
  p_req_armed_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (rc_req || xtal_req) |-> armed);
endmodule

// File: tb/dslp_wdt_tb.sv
module dslp_wdt_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, cfg_en, cfg_clk_sel, sleep_entry, sleep_exit;
  logic [3:0] cfg_ps;
  logic       rc_tick, rc_ready, xtal_tick, xtal_ready;
  logic       wake_pulse, wake_flag, rc_req, xtal_req;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dslp_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_clk_sel(cfg_clk_sel),
    .cfg_ps(cfg_ps), .sleep_entry(sleep_entry), .sleep_exit(sleep_exit),
    .rc_tick(rc_tick), .rc_ready(rc_ready), .xtal_tick(xtal_tick),
    .xtal_ready(xtal_ready), .wake_pulse(wake_pulse), .wake_flag(wake_flag),
    .rc_req(rc_req), .xtal_req(xtal_req)
  );

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every wake pulse must match the head of the scoreboard queue
  always @(posedge clk) begin
    #1;
    if (wake_pulse) begin
      if (exp_q.size() == 0) check("R8/R10 unexpected pulse", cyc, -1);
      else check("R5 pulse cycle", cyc, exp_q.pop_front());
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // entry edge = cyc+1; pulse edge = entry edge + period
  task automatic enter(int period, bit expect_wake);
    @(negedge clk);
    sleep_entry = 1'b1;
    if (expect_wake) exp_q.push_back(cyc + 1 + period);
    @(negedge clk);
    sleep_entry = 1'b0;
  endtask

  task automatic run_all();
    int c;
    rst_n = 1'b0; cfg_en = 1'b1; cfg_clk_sel = 1'b0; cfg_ps = 4'd0;
    sleep_entry = 1'b0; sleep_exit = 1'b0;
    rc_tick = 1'b1; rc_ready = 1'b1; xtal_tick = 1'b1; xtal_ready = 1'b1;
    wait_n(3);
    check("R1 reset flag", wake_flag, 0);
    check("R1 reset req", rc_req | xtal_req, 0);
    rst_n = 1'b1;
    wait_n(4);
    check("R1 post-reset pulse", wake_pulse, 0);
    check("R1 post-reset req", {rc_req, xtal_req}, 0);

    // R5/R6/R8: code 0 on RC source
    enter(64, 1);
    check("R6 rc_req", rc_req, 1);
    check("R6 xtal_req", xtal_req, 0);
    wait_n(80);
    check("R8 flag set", wake_flag, 1);
    check("R8 stopped, req dropped", rc_req, 0);
    wait_n(200);
    check("R8 flag sticky", wake_flag, 1);

    // R9/R7/R4: crystal source, not ready at entry
    cfg_clk_sel = 1'b1; cfg_ps = 4'd1; xtal_ready = 1'b0;
    enter(0, 0);
    check("R9 flag cleared", wake_flag, 0);
    check("R6 xtal_req", xtal_req, 1);
    check("R6 rc_req off", rc_req, 0);
    wait_n(300);
    check("R7 no count while not ready", wake_flag, 0);
    @(negedge clk);
    xtal_ready = 1'b1;
    exp_q.push_back(cyc + 256);
    wait_n(300);
    check("R4 crystal period, rc ticks ignored", wake_flag, 1);

    // R3: re-entry restarts
    cfg_clk_sel = 1'b0; cfg_ps = 4'd0;
    enter(0, 0);
    wait_n(40);
    enter(64, 1);
    wait_n(100);
    check("R3 restart then wake", wake_flag, 1);

    // R10: exit disarms
    enter(0, 0);
    wait_n(30);
    @(negedge clk); sleep_exit = 1'b1;
    @(negedge clk); sleep_exit = 1'b0;
    check("R10 req dropped on exit", rc_req, 0);
    wait_n(200);
    check("R10 no wake after exit", wake_flag, 0);

    // R11: entry on the terminal edge wins
    enter(0, 0);
    c = cyc - 1;
    while (cyc != c + 64) @(negedge clk);
    sleep_entry = 1'b1;
    exp_q.push_back(cyc + 1 + 64);
    @(negedge clk);
    sleep_entry = 1'b0;
    check("R11 flag after coincident entry", wake_flag, 0);
    wait_n(100);
    check("R11 single fresh wake", wake_flag, 1);

    // R2: disabled
    cfg_en = 1'b0;
    enter(0, 0);
    check("R2 no req when disabled", rc_req | xtal_req, 0);
    wait_n(200);
    check("R2 no wake when disabled", wake_flag, 0);
    cfg_en = 1'b1;

    // R5: longer codes
    cfg_ps = 4'd2;
    enter(1024, 1);
    wait_n(1100);
    check("R5 code 2 wake", wake_flag, 1);
    cfg_ps = 4'd4;
    enter(16384, 1);
    wait_n(16300);
    check("R5 code 4 not early", wake_flag, 0);
    wait_n(200);
    check("R5 code 4 wake", wake_flag, 1);

    // R12: POR mid-count
    cfg_ps = 4'd0;
    enter(0, 0);
    wait_n(20);
    rst_n = 1'b0;
    wait_n(3);
    check("R12 req cleared", rc_req, 0);
    rst_n = 1'b1;
    wait_n(150);
    check("R12 no wake after POR", wake_flag, 0);
    check("R12 idle req", rc_req | xtal_req, 0);
    check("R5 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule